// File: doc/BRIEF.md
# DRAM Initialization and Refresh Sequencer

This block runs the housekeeping of an asynchronous DRAM on behalf of the access controller that sits above it. After reset it waits out the power-up pause. It then asks for a fixed number of dummy row-strobe cycles, and after those it reports that the memory may be used. While the pause and the dummy cycles are in progress, host traffic is held off.

Once initialization is over, the block keeps a timer that comes due once per refresh interval. The interval is the retention time divided by the number of rows, so every row is refreshed within the retention time. Each due refresh adds one to a count of outstanding refreshes. The controller performs them when it can, and acknowledges each one with a grant while the request is up. Only a bounded number of refreshes may be postponed. If one more comes due when that many are already waiting, a sticky error flag is raised.

A static parameter chooses between two refresh styles. In the CAS-before-RAS style the memory counts rows itself, so no address is needed. In the RAS-only style this block supplies the row address, and steps it on every accepted refresh. Time is measured with a microsecond tick divided down from the clock, using a clock-frequency parameter.

Top module: `dram_hk_seq`

## Requirements
- R1: While reset is asserted, and for the whole power-up pause after reset, ref_req, init_done, host_ok, ref_err and backlog are 0 and ref_row is 0. ref_req first rises exactly 2 + PAUSE_US*CLK_MHZ clock edges after rst_n is released; the first 2 edges are reset synchronization.
- R2: After the pause, ref_req stays high until INIT_CYCLES grants have been accepted. A grant is accepted on a rising edge where ref_gnt and ref_req are both 1. init_done rises on the edge of the last accepted init grant, and ref_req is then 0.
- R3: host_ok equals host_req while init_done is 1, and it is 0 before that.
- R4: After initialization, a refresh comes due every REFI_US*CLK_MHZ clock cycles, where REFI_US = RETENTION_US/ROWS in whole microseconds. Each due refresh raises backlog by 1.
- R5: Each accepted grant lowers backlog by 1. A grant and a due refresh on the same edge leave backlog unchanged. ref_req is 1 exactly when backlog is non-zero.
- R6: backlog saturates at BACKLOG_MAX. A refresh that comes due when backlog is already BACKLOG_MAX sets ref_err, and ref_err then stays 1 until reset.
- R7: ref_gnt has no effect while ref_req is 0. It changes neither backlog nor ref_row.
- R8: With USE_CBR=0, ref_cbr is 0, and ref_row advances by 1 on each accepted grant (init and refresh alike), wrapping from ROWS-1 to 0.
- R9: With USE_CBR=1, ref_cbr is 1 and ref_row stays 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Controller accepts the pending refresh/init cycle |
| host_req | input | 1 | Host access request from the controller side |
| ref_req | output | 1 | An init or refresh cycle is wanted |
| ref_row | output | ROW_W | Row to strobe in RAS-only style |
| ref_cbr | output | 1 | 1 when cycles must be CAS-before-RAS |
| backlog | output | BL_W | Refreshes due but not yet granted |
| ref_err | output | 1 | Sticky: backlog limit exceeded |
| init_done | output | 1 | Pause and init cycles complete |
| host_ok | output | 1 | host_req passed through once initialized |

## Verification
The checker places no restriction on ref_gnt. It may be high in any cycle, including cycles where nothing is requested, so the properties on backlog steps and row steps must hold for any grant pattern. The checker does assume that USE_CBR is a constant, and that rst_n reaches the block only through its own synchronizer. The stimulus drives ref_gnt and host_req only at falling edges. It holds grants for whole cycles, and it issues a stray grant only between two due refreshes, so that its effect can be read at the ports before the next refresh comes due.

// File: rtl/dram_hk_pkg.sv
package dram_hk_pkg;
  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_INIT  = 2'd1,
    PH_RUN   = 2'd2
  } hk_phase_e;
endpackage

// File: rtl/dram_hk_us_tick.sv
module dram_hk_us_tick #(
  parameter int DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dram_hk_init_ctl.sv
module dram_hk_init_ctl
  import dram_hk_pkg::*;
#(
  parameter int PAUSE_US    = 100,
  parameter int INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic gnt,
  output logic init_phase,
  output logic run
);
  localparam int PW = $clog2(PAUSE_US) + 1;
  localparam int IW = $clog2(INIT_CYCLES) + 1;
  localparam logic [PW-1:0] P_LAST = PW'(PAUSE_US - 1);
  localparam logic [IW-1:0] I_LAST = IW'(INIT_CYCLES - 1);

  hk_phase_e      ph_q, ph_d;
  logic [PW-1:0]  pcnt_q, pcnt_d;
  logic [IW-1:0]  icnt_q, icnt_d;

  always_comb begin
    ph_d   = ph_q;
    pcnt_d = pcnt_q;
    icnt_d = icnt_q;
    unique case (ph_q)
      PH_PAUSE: if (tick) begin
        if (pcnt_q == P_LAST) ph_d = PH_INIT;
        else                  pcnt_d = pcnt_q + 1'b1;
      end
      PH_INIT: if (gnt) begin
        if (icnt_q == I_LAST) ph_d = PH_RUN;
        else                  icnt_d = icnt_q + 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_PAUSE;
      pcnt_q <= '0;
      icnt_q <= '0;
    end else begin
      ph_q   <= ph_d;
      pcnt_q <= pcnt_d;
      icnt_q <= icnt_d;
    end
  end

  assign init_phase = (ph_q == PH_INIT);
  assign run        = (ph_q == PH_RUN);
endmodule

// File: rtl/dram_hk_ref_sched.sv
module dram_hk_ref_sched #(
  parameter int REFI_US     = 62,
  parameter int ROWS        = 1024,
  parameter int BACKLOG_MAX = 8,
  parameter bit USE_CBR     = 1'b0,
  localparam int ROW_W      = $clog2(ROWS),
  localparam int BL_W       = $clog2(BACKLOG_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             init_phase,
  input  logic             gnt,
  output logic             req,
  output logic [ROW_W-1:0] row,
  output logic [BL_W-1:0]  pend,
  output logic             err
);
  localparam int RW = (REFI_US > 1) ? $clog2(REFI_US) : 1;
  localparam logic [RW-1:0]    R_LAST   = RW'(REFI_US - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [BL_W-1:0]  BL_FULL  = BL_W'(BACKLOG_MAX);

  logic [RW-1:0]    ri_q, ri_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [BL_W-1:0]  pend_q, pend_d;
  logic             err_q, err_d;
  logic             due, acc;

  always_comb begin
    req = init_phase | (pend_q != '0);
    acc = gnt & req;
    due = run & tick & (ri_q == R_LAST);

    if (!run)      ri_d = '0;
    else if (tick) ri_d = (ri_q == R_LAST) ? '0 : ri_q + 1'b1;
    else           ri_d = ri_q;

    pend_d = pend_q;
    err_d  = err_q;
    if (run) begin
      if (due && !acc) begin
        if (pend_q == BL_FULL) err_d  = 1'b1;
        else                   pend_d = pend_q + 1'b1;
      end else if (acc && !due) begin
        pend_d = pend_q - 1'b1;
      end
    end

    row_d = row_q;
    if (!USE_CBR && acc) row_d = (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ri_q   <= '0;
      row_q  <= '0;
      pend_q <= '0;
      err_q  <= 1'b0;
    end else begin
      ri_q   <= ri_d;
      row_q  <= row_d;
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  assign row  = row_q;
  assign pend = pend_q;
  assign err  = err_q;
endmodule

// File: rtl/dram_hk_seq.sv
module dram_hk_seq #(
  parameter int CLK_MHZ      = 125,
  parameter int PAUSE_US     = 100,
  parameter int INIT_CYCLES  = 8,
  parameter int ROWS         = 1024,
  parameter int RETENTION_US = 64000,
  parameter int BACKLOG_MAX  = 8,
  parameter bit USE_CBR      = 1'b0,
  localparam int ROW_W       = $clog2(ROWS),
  localparam int BL_W        = $clog2(BACKLOG_MAX + 1),
  localparam int REFI_US     = RETENTION_US / ROWS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_gnt,
  input  logic             host_req,
  output logic             ref_req,
  output logic [ROW_W-1:0] ref_row,
  output logic             ref_cbr,
  output logic [BL_W-1:0]  backlog,
  output logic             ref_err,
  output logic             init_done,
  output logic             host_ok
);
  logic [1:0] rsync_q;
  logic       rst_sync_n;
  logic       tick, init_phase, run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  dram_hk_us_tick #(.DIV(CLK_MHZ)) u_tick (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick)
  );

  dram_hk_init_ctl #(.PAUSE_US(PAUSE_US), .INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .gnt(ref_gnt),
    .init_phase(init_phase), .run(run)
  );

  dram_hk_ref_sched #(
    .REFI_US(REFI_US), .ROWS(ROWS), .BACKLOG_MAX(BACKLOG_MAX), .USE_CBR(USE_CBR)
  ) u_sched (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .run(run),
    .init_phase(init_phase), .gnt(ref_gnt), .req(ref_req),
    .row(ref_row), .pend(backlog), .err(ref_err)
  );

  assign ref_cbr   = USE_CBR;
  assign init_done = run;
  assign host_ok   = host_req & run;
endmodule

// File: rtl/dram_hk_seq_chk.sv
module dram_hk_seq_chk #(
  parameter int ROWS        = 1024,
  parameter int BACKLOG_MAX = 8,
  parameter bit USE_CBR     = 1'b0,
  localparam int ROW_W      = $clog2(ROWS),
  localparam int BL_W       = $clog2(BACKLOG_MAX + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_gnt,
  input logic             ref_req,
  input logic [ROW_W-1:0] ref_row,
  input logic [BL_W-1:0]  backlog,
  input logic             ref_err,
  input logic             init_done
);
  localparam logic [BL_W-1:0]  BL_FULL  = BL_W'(BACKLOG_MAX);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  AST_DONE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(ref_gnt && ref_req)); // R2
  AST_BACKLOG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    backlog <= BL_FULL); // R6
  AST_BACKLOG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> (backlog == $past(backlog)) || (backlog == $past(backlog) + 1'b1)
                  || (backlog + 1'b1 == $past(backlog))); // R5
  AST_REQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (ref_req == (backlog != '0))); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ref_err |=> ref_err); // R6
  AST_ERR_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_err) |-> (backlog == BL_FULL) && ($past(backlog) == BL_FULL)); // R6
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_gnt && ref_req) |=> $stable(ref_row)); // R7
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_gnt && ref_req) |=> (USE_CBR ? (ref_row == '0) :
      (ref_row == (($past(ref_row) == ROW_LAST) ? '0 : $past(ref_row) + 1'b1)))); // R8
endmodule

bind dram_hk_seq dram_hk_seq_chk #(
  .ROWS(ROWS), .BACKLOG_MAX(BACKLOG_MAX), .USE_CBR(USE_CBR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
  .ref_row(ref_row), .backlog(backlog), .ref_err(ref_err), .init_done(init_done)
);

// File: tb/dram_hk_seq_tb.sv
module dram_hk_seq_tb;
  localparam int CLK_MHZ = 4;
  localparam int PAUSE   = 10;
  localparam int ROWS    = 1024;
  localparam int RET_US  = 4096;
  localparam int PERIOD  = (RET_US / ROWS) * CLK_MHZ;

  logic clk, rst_n, gnt, host_req;
  logic req, cbr, err, done, hok;
  logic [9:0] row;
  logic [3:0] bl;
  logic c_req, c_cbr, c_err, c_done, c_hok;
  logic [9:0] c_row;
  logic [3:0] c_bl;

  int n_chk = 0;
  int n_fail = 0;
  int exp_row = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  dram_hk_seq #(.CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE), .ROWS(ROWS),
    .RETENTION_US(RET_US), .USE_CBR(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .host_req(host_req),
    .ref_req(req), .ref_row(row), .ref_cbr(cbr), .backlog(bl),
    .ref_err(err), .init_done(done), .host_ok(hok));

  dram_hk_seq #(.CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE), .ROWS(ROWS),
    .RETENTION_US(RET_US), .USE_CBR(1'b1)) u_dut_cbr (
    .clk(clk), .rst_n(rst_n), .ref_gnt(c_req), .host_req(host_req),
    .ref_req(c_req), .ref_row(c_row), .ref_cbr(c_cbr), .backlog(c_bl),
    .ref_err(c_err), .init_done(c_done), .host_ok(c_hok));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic grant_cycles(input int k);
    for (int i = 0; i < k; i++) begin
      if (req) exp_row = (exp_row + 1) % ROWS;
      gnt = 1'b1;
      @(negedge clk);
    end
    gnt = 1'b0;
  endtask

  task automatic wait_req(output int cnt);
    cnt = 0;
    while (!req) begin
      @(posedge clk); cnt++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; gnt = 1'b0; host_req = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 req in reset", int'(req), 0);
    check("R1 done/host_ok/err in reset", int'({done, hok, err}), 0);
    check("R1 row/backlog in reset", int'(row) + int'(bl), 0);
  endtask

  task automatic t_pause();
    int n;
    rst_n = 1'b1;
    wait_req(n);
    check("R1 pause length", n, 2 + PAUSE * CLK_MHZ);
    check("R3 host blocked during init", int'(hok), 0);
  endtask

  task automatic t_init();
    grant_cycles(7);
    check("R2 still requesting after 7 grants", int'(req), 1);
    check("R2 not done after 7 grants", int'(done), 0);
    check("R8 row after 7 init grants", int'(row), 7);
    grant_cycles(1);
    check("R2 done after 8th grant", int'(done), 1);
    check("R2 req drops after init", int'(req), 0);
    check("R3 host passes after init", int'(hok), 1);
    host_req = 1'b0; #1;
    check("R3 host_ok follows host_req", int'(hok), 0);
    host_req = 1'b1;
    check("R8 ref_cbr low in RAS-only", int'(cbr), 0);
  endtask

  task automatic t_interval();
    int n;
    wait_req(n);
    check("R4 first due backlog", int'(bl), 1);
    gnt = 1'b1; exp_row++;
    @(posedge clk); @(negedge clk); gnt = 1'b0;
    check("R5 grant drains backlog", int'(bl), 0);
    wait_req(n);
    check("R4 refresh spacing", n + 1, PERIOD);
    grant_cycles(1);
    check("R8 row after interval grants", int'(row), exp_row);
  endtask

  task automatic t_backlog();
    int n;
    wait_req(n);
    check("R4 backlog 1", int'(bl), 1);
    for (int k = 2; k <= 8; k++) repeat (PERIOD) @(negedge clk);
    check("R4 backlog reaches 8", int'(bl), 8);
    check("R6 no error at limit", int'(err), 0);
    repeat (PERIOD) @(negedge clk);
    check("R6 backlog saturates", int'(bl), 8);
    check("R6 error on overflow", int'(err), 1);
    grant_cycles(3);
    check("R5 backlog after 3 grants", int'(bl), 5);
    grant_cycles(5);
    check("R5 backlog drained", int'(bl), 0);
    check("R5 req low when drained", int'(req), 0);
    gnt = 1'b1; @(negedge clk); gnt = 1'b0;
    check("R7 stray grant backlog", int'(bl), 0);
    check("R7 stray grant row", int'(row), exp_row);
    check("R6 error sticky", int'(err), 1);
  endtask

  task automatic t_wrap();
    int n;
    while (exp_row != ROWS - 1) begin
      wait_req(n);
      grant_cycles(1);
    end
    check("R8 row at last", int'(row), ROWS - 1);
    wait_req(n);
    grant_cycles(1);
    check("R8 row wraps to 0", int'(row), 0);
  endtask

  task automatic t_cbr();
    check("R9 cbr flag", int'(c_cbr), 1);
    check("R9 cbr row stays 0", int'(c_row), 0);
    check("R9 cbr init done", int'(c_done), 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_pause();
    t_init();
    t_interval();
    t_backlog();
    t_wrap();
    t_cbr();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule